// File: doc/BRIEF.md
# SMBus Byte-Access Configuration Slave

This block is an SMBus slave that gives an external bus master read and write access to a chip's internal configuration and status registers. It answers only at its own 7-bit bus address and understands exactly two transactions: Write Byte (address with write bit, command, data) and Read Byte (address with write bit, command, repeated START, address with read bit, one byte returned). The command byte is taken as an 8-bit register offset. There is no packet error checking, so no PEC byte is sent and any byte after the expected ones is refused.

Since one offset byte reaches only 256 locations, the slave keeps a small bank-select register at a reserved offset that appears in every 256-byte record. The selected bank is joined to the offset to form the address on the internal register bus. That bus has an address, write data, a one-cycle write strobe, a one-cycle read strobe and read data that is valid in the strobe cycle. SDA and SCL are open-drain lines. They enter through a synchronizer. The slave pulls SDA low through a single drive-enable output and never holds SCL.

Top module: `smb_cfg_slave`

## Requirements
- R1: An address byte whose upper seven bits differ from SLAVE_ADDR is not acknowledged (SDA stays high in the ninth clock), and the rest of that transaction raises no register strobe.
- R2: In a Write Byte to SLAVE_ADDR, the slave acknowledges the address byte, the command byte and the data byte by holding SDA low through the ninth SCL high phase of each.
- R3: A Write Byte to any offset other than BANK_OFF produces exactly one single-cycle reg_wr. It occurs after the data byte's eighth bit, with reg_addr = {bank, command} and reg_wdata = data. reg_wr and reg_rd are never high together.
- R4: In a Read Byte, the slave acknowledges the command and the read address. It then shifts out, MSB first, the byte that reg_rdata presented in the cycle it pulsed reg_rd with reg_addr = {bank, command}. It leaves SDA released during the master's NACK clock.
- R5: A write to offset BANK_OFF (default 8'hFF) in any record loads the bank register with the low BANK_W bits of the data and does not raise reg_wr. A read of BANK_OFF returns the bank zero-extended to 8 bits and does not raise reg_rd. The bank resets to 0.
- R6: Transactions other than Read Byte and Write Byte are refused without state change. A read address with no command acknowledged earlier in the same transaction is not acknowledged. Any byte after the data byte of a Write Byte, including a would-be PEC byte, is not acknowledged. An address and command ended by STOP cause no write.
- R7: A START or STOP at any point returns the bit and byte sequencer to its initial state and releases SDA. A transaction cut off mid-byte has no effect on registers or strobes.
- R8: During and after reset, sda_oe, reg_wr and reg_rd are low.
- R9: The slave changes its SDA drive only while SCL is low. Once SCL has been high for four clocks, sda_oe holds steady until SCL falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| reg_addr | output | BANK_W+8 | Register bus address {bank, offset} |
| reg_wdata | output | 8 | Register bus write data |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_rdata | input | 8 | Register read data, valid while reg_rd is high |

## Verification
Both legal transactions are run with data patterns 8'hA5, 8'h5A, 8'h00 and 8'hFF at low, middle and top offsets. These show up bit-order or stuck-bit faults in the shifter. The same offset is written in two banks and read back from each, and that separates a working bank join from one that ignores the bank. Malformed traffic is also driven: a foreign address, a read with no command, an extra trailing byte, a command with no data, and transfers cut off by STOP and by repeated START. Each of these must leave the strobe stream exactly as a behavioural scoreboard predicts. That scoreboard is compared on every clock.

// File: rtl/smb_pkg.sv
package smb_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_CMD,
        PH_WDATA,
        PH_TX,
        PH_IGNORE
    } phase_t;

    localparam int unsigned BYTE_BITS = 8;

endpackage

// File: rtl/smb_line_mon.sv
module smb_line_mon #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int unsigned MSB = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] scl_sh;
        logic [SYNC_STAGES-1:0] sda_sh;
        logic                   scl_p;
        logic                   sda_p;
    } mon_t;

    mon_t mon_d, mon_q;

    always_comb begin
        mon_d        = mon_q;
        mon_d.scl_sh = {mon_q.scl_sh[MSB-1:0], scl_i};
        mon_d.sda_sh = {mon_q.sda_sh[MSB-1:0], sda_i};
        mon_d.scl_p  = mon_q.scl_sh[MSB];
        mon_d.sda_p  = mon_q.sda_sh[MSB];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mon_q <= '1;
        end else begin
            mon_q <= mon_d;
        end
    end

    logic scl_now, sda_now;
    assign scl_now   = mon_q.scl_sh[MSB];
    assign sda_now   = mon_q.sda_sh[MSB];
    assign sda_s     = sda_now;
    assign scl_rise  = scl_now & ~mon_q.scl_p;
    assign scl_fall  = ~scl_now & mon_q.scl_p;
    assign start_det = scl_now & mon_q.scl_p & mon_q.sda_p & ~sda_now;
    assign stop_det  = scl_now & mon_q.scl_p & ~mon_q.sda_p & sda_now;

endmodule

// File: rtl/smb_bank_sel.sv
module smb_bank_sel #(
    parameter int unsigned BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [7:0]        wdata,
    output logic [BANK_W-1:0] bank
);
    logic [BANK_W-1:0] bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (load) begin
            bank_d = wdata[BANK_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign bank = bank_q;

endmodule

// File: rtl/smb_byte_fsm.sv
module smb_byte_fsm
    import smb_pkg::*;
#(
    parameter logic [6:0]  SLAVE_ADDR = 7'h3A,
    parameter logic [7:0]  BANK_OFF   = 8'hFF,
    parameter int unsigned BANK_W     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [BANK_W-1:0] bank,
    input  logic [7:0]        rd_data,
    output logic              sda_oe,
    output logic [7:0]        offset,
    output logic [7:0]        wr_data,
    output logic              wr_pulse,
    output logic              rd_pulse,
    output logic              bank_load
);
    localparam logic [3:0] LAST_BIT = 4'(BYTE_BITS - 1);
    localparam logic [3:0] ACK_SLOT = 4'(BYTE_BITS);
    localparam logic [3:0] ACK_DONE = 4'(BYTE_BITS + 1);

    typedef struct packed {
        phase_t     phase;
        logic [3:0] bitcnt;
        logic [7:0] shreg;
        logic       rw;
        logic       ack;
        logic       cmd_ok;
        logic [7:0] offset;
        logic [7:0] tx;
        logic       sda_oe;
    } fsm_t;

    fsm_t st_d, st_q;
    logic [7:0] nb;

    always_comb begin
        st_d      = st_q;
        wr_pulse  = 1'b0;
        rd_pulse  = 1'b0;
        bank_load = 1'b0;
        nb        = {st_q.shreg[6:0], sda_s};

        if (stop_det) begin
            st_d.phase  = PH_IDLE;
            st_d.bitcnt = '0;
            st_d.sda_oe = 1'b0;
            st_d.cmd_ok = 1'b0;
        end else if (start_det) begin
            st_d.phase  = PH_ADDR;
            st_d.bitcnt = '0;
            st_d.sda_oe = 1'b0;
        end else if (scl_rise) begin
            unique case (st_q.phase)
                PH_ADDR, PH_CMD, PH_WDATA: begin
                    if (st_q.bitcnt < ACK_SLOT) begin
                        st_d.shreg  = nb;
                        st_d.bitcnt = st_q.bitcnt + 4'd1;
                        if (st_q.bitcnt == LAST_BIT) begin
                            unique case (st_q.phase)
                                PH_ADDR: begin
                                    st_d.rw     = nb[0];
                                    st_d.cmd_ok = 1'b0;
                                    if (nb[7:1] != SLAVE_ADDR) begin
                                        st_d.ack = 1'b0;
                                    end else if (!nb[0]) begin
                                        st_d.ack = 1'b1;
                                    end else if (st_q.cmd_ok) begin
                                        st_d.ack = 1'b1;
                                        if (st_q.offset == BANK_OFF) begin
                                            st_d.tx = 8'(bank);
                                        end else begin
                                            rd_pulse = 1'b1;
                                            st_d.tx  = rd_data;
                                        end
                                    end else begin
                                        st_d.ack = 1'b0;
                                    end
                                end
                                PH_CMD: begin
                                    st_d.ack    = 1'b1;
                                    st_d.offset = nb;
                                    st_d.cmd_ok = 1'b1;
                                end
                                default: begin
                                    st_d.ack    = 1'b1;
                                    st_d.cmd_ok = 1'b0;
                                    if (st_q.offset == BANK_OFF) begin
                                        bank_load = 1'b1;
                                    end else begin
                                        wr_pulse = 1'b1;
                                    end
                                end
                            endcase
                        end
                    end else if (st_q.bitcnt == ACK_SLOT) begin
                        st_d.bitcnt = ACK_DONE;
                    end
                end
                PH_TX: begin
                    if (st_q.bitcnt < ACK_SLOT) begin
                        st_d.bitcnt = st_q.bitcnt + 4'd1;
                    end else begin
                        st_d.phase  = PH_IGNORE;
                        st_d.sda_oe = 1'b0;
                    end
                end
                default: begin
                end
            endcase
        end else if (scl_fall) begin
            unique case (st_q.phase)
                PH_ADDR, PH_CMD, PH_WDATA: begin
                    if (st_q.bitcnt == ACK_SLOT) begin
                        st_d.sda_oe = st_q.ack;
                    end else if (st_q.bitcnt == ACK_DONE) begin
                        st_d.sda_oe = 1'b0;
                        st_d.bitcnt = '0;
                        if (!st_q.ack) begin
                            st_d.phase = PH_IGNORE;
                        end else begin
                            unique case (st_q.phase)
                                PH_ADDR: begin
                                    if (st_q.rw) begin
                                        st_d.phase  = PH_TX;
                                        st_d.sda_oe = ~st_q.tx[7];
                                    end else begin
                                        st_d.phase = PH_CMD;
                                    end
                                end
                                PH_CMD:  st_d.phase = PH_WDATA;
                                default: st_d.phase = PH_IGNORE;
                            endcase
                        end
                    end
                end
                PH_TX: begin
                    if (st_q.bitcnt >= 4'd1 && st_q.bitcnt <= LAST_BIT) begin
                        st_d.tx     = {st_q.tx[6:0], 1'b0};
                        st_d.sda_oe = ~st_q.tx[6];
                    end else if (st_q.bitcnt == ACK_SLOT) begin
                        st_d.sda_oe = 1'b0;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, bitcnt: '0, shreg: '0, rw: 1'b0,
                      ack: 1'b0, cmd_ok: 1'b0, offset: '0, tx: '0,
                      sda_oe: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign sda_oe  = st_q.sda_oe;
    assign offset  = st_q.offset;
    assign wr_data = nb;

endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave #(
    parameter logic [6:0]  SLAVE_ADDR  = 7'h3A,
    parameter int unsigned BANK_W      = 2,
    parameter logic [7:0]  BANK_OFF    = 8'hFF,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [BANK_W+7:0] reg_addr,
    output logic [7:0]        reg_wdata,
    output logic              reg_wr,
    output logic              reg_rd,
    input  logic [7:0]        reg_rdata
);
    logic              sda_s;
    logic              scl_rise, scl_fall;
    logic              start_det, stop_det;
    logic              bank_load;
    logic [BANK_W-1:0] bank;
    logic [7:0]        offset;

    smb_line_mon #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_mon (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    smb_byte_fsm #(
        .SLAVE_ADDR(SLAVE_ADDR),
        .BANK_OFF  (BANK_OFF),
        .BANK_W    (BANK_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det),
        .bank     (bank),
        .rd_data  (reg_rdata),
        .sda_oe   (sda_oe),
        .offset   (offset),
        .wr_data  (reg_wdata),
        .wr_pulse (reg_wr),
        .rd_pulse (reg_rd),
        .bank_load(bank_load)
    );

    smb_bank_sel #(
        .BANK_W(BANK_W)
    ) u_bank (
        .clk  (clk),
        .rst_n(rst_n),
        .load (bank_load),
        .wdata(reg_wdata),
        .bank (bank)
    );

    assign reg_addr = {bank, offset};

endmodule

// File: rtl/smb_cfg_slave_chk.sv
module smb_cfg_slave_chk #(
    parameter logic [7:0] BANK_OFF = 8'hFF
) (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       sda_oe,
    input logic       reg_wr,
    input logic       reg_rd,
    input logic [7:0] offset,
    input logic       start_det,
    input logic       stop_det
);
    logic [2:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt <= '0;
        end else if (!scl_i) begin
            hi_cnt <= '0;
        end else if (hi_cnt != 3'd7) begin
            hi_cnt <= hi_cnt + 3'd1;
        end
    end

    AST_WR_RD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_rd)); // R3
    AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr); // R3
    AST_BANK_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> (offset != BANK_OFF)); // R5
    AST_BANK_NO_RD: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |-> (offset != BANK_OFF)); // R5
    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe); // R7
    AST_START_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_oe); // R7
    AST_SDA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_cnt >= 3'd4) |-> $stable(sda_oe)); // R9

endmodule

bind smb_cfg_slave smb_cfg_slave_chk #(
    .BANK_OFF(BANK_OFF)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_oe   (sda_oe),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .offset   (reg_addr[7:0]),
    .start_det(start_det),
    .stop_det (stop_det)
);

// File: tb/sim_smb_cfg_slave.sv
module sim_smb_cfg_slave;
    localparam logic [6:0] DEV   = 7'h3A;
    localparam int         HALF  = 10;
    localparam int         BW    = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic m_scl_low = 1'b0;
    logic m_sda_low = 1'b0;
    logic sda_oe;
    logic scl_line, sda_line;
    assign scl_line = ~m_scl_low;
    assign sda_line = ~(m_sda_low | sda_oe);

    logic [BW+7:0] reg_addr;
    logic [7:0]    reg_wdata, reg_rdata;
    logic          reg_wr, reg_rd;
    logic [7:0]    mem [0:(1<<(BW+8))-1];
    assign reg_rdata = mem[reg_addr];

    smb_cfg_slave u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata)
    );

    always @(posedge clk) if (reg_wr) mem[reg_addr] <= reg_wdata;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // behavioural reference state
    logic [7:0]    ref_mem [0:(1<<(BW+8))-1];
    logic [BW-1:0] ref_bank = '0;
    logic [17:0]   exp_wq[$];
    logic [9:0]    exp_rq[$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-clock scoreboard of the register bus and SDA timing
    int hi_run = 0;
    logic prev_oe = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (reg_wr) begin
                if (exp_wq.size() == 0) chk(1'b0, "R3 unexpected reg_wr", int'(reg_addr), 0);
                else begin
                    logic [17:0] e;
                    e = exp_wq.pop_front();
                    chk({reg_addr, reg_wdata} == e, "R3 write addr/data", int'({reg_addr, reg_wdata}), int'(e));
                end
            end
            if (reg_rd) begin
                if (exp_rq.size() == 0) chk(1'b0, "R4 unexpected reg_rd", int'(reg_addr), 0);
                else begin
                    logic [9:0] e;
                    e = exp_rq.pop_front();
                    chk(reg_addr == e, "R4 read addr", int'(reg_addr), int'(e));
                end
            end
            if (reg_wr && reg_rd) chk(1'b0, "R3 wr and rd together", 1, 0);
            if (hi_run >= 5 && sda_oe != prev_oe) chk(1'b0, "R9 SDA changed with SCL high", int'(sda_oe), int'(prev_oe));
            hi_run = scl_line ? hi_run + 1 : 0;
            prev_oe = sda_oe;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic m_start();
        m_sda_low = 1'b1; tick(HALF); m_scl_low = 1'b1; tick(2);
    endtask

    task automatic m_rstart();
        m_sda_low = 1'b0; tick(HALF - 2); m_scl_low = 1'b0; tick(HALF);
        m_sda_low = 1'b1; tick(HALF); m_scl_low = 1'b1; tick(2);
    endtask

    task automatic m_stop();
        m_sda_low = 1'b1; tick(HALF - 2); m_scl_low = 1'b0; tick(HALF);
        m_sda_low = 1'b0; tick(HALF);
    endtask

    task automatic m_bits(input logic [7:0] b, input int nbits);
        for (int i = 7; i > 7 - nbits; i--) begin
            m_sda_low = ~b[i]; tick(HALF - 2);
            m_scl_low = 1'b0;  tick(HALF);
            m_scl_low = 1'b1;  tick(2);
        end
    endtask

    task automatic m_byte(input logic [7:0] b, output bit acked);
        m_bits(b, 8);
        m_sda_low = 1'b0; tick(HALF - 2);
        m_scl_low = 1'b0; tick(HALF / 2);
        acked = ~sda_line; tick(HALF - HALF / 2);
        m_scl_low = 1'b1; tick(2);
    endtask

    task automatic m_read(output logic [7:0] b, output bit released);
        m_sda_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            tick(HALF - 2);
            m_scl_low = 1'b0; tick(HALF / 2);
            b[i] = sda_line; tick(HALF - HALF / 2);
            m_scl_low = 1'b1; tick(2);
        end
        tick(HALF - 2);                      // master NACK: SDA left high
        m_scl_low = 1'b0; tick(HALF / 2);
        released = ~sda_oe; tick(HALF - HALF / 2);
        m_scl_low = 1'b1; tick(2);
    endtask

    // reference: what a Write Byte should do
    task automatic model_write(input logic [7:0] cmd, input logic [7:0] d);
        if (cmd == 8'hFF) ref_bank = d[BW-1:0];
        else begin
            exp_wq.push_back({ref_bank, cmd, d});
            ref_mem[{ref_bank, cmd}] = d;
        end
    endtask

    task automatic do_write(input logic [7:0] cmd, input logic [7:0] d, input string tag);
        bit a0, a1, a2;
        model_write(cmd, d);
        m_start(); m_byte({DEV, 1'b0}, a0); m_byte(cmd, a1); m_byte(d, a2); m_stop();
        chk(a0 && a1 && a2, {tag, " acks on Write Byte"}, int'({a0, a1, a2}), 7);
    endtask

    task automatic do_read(input logic [7:0] cmd, input string tag);
        bit a0, a1, a2, rel;
        logic [7:0] got, exp;
        exp = (cmd == 8'hFF) ? 8'(ref_bank) : ref_mem[{ref_bank, cmd}];
        if (cmd != 8'hFF) exp_rq.push_back({ref_bank, cmd});
        m_start(); m_byte({DEV, 1'b0}, a0); m_byte(cmd, a1);
        m_rstart(); m_byte({DEV, 1'b1}, a2); m_read(got, rel); m_stop();
        chk(a0 && a1 && a2, {tag, " acks on Read Byte"}, int'({a0, a1, a2}), 7);
        chk(got == exp, {tag, " read data"}, int'(got), int'(exp));
        chk(rel, "R4 SDA released in NACK clock", int'(rel), 1);
    endtask

    initial begin
        for (int i = 0; i < (1 << (BW + 8)); i++) begin
            mem[i] = 8'h00;
            ref_mem[i] = 8'h00;
        end
        tick(5);
        chk(sda_oe == 1'b0 && reg_wr == 1'b0 && reg_rd == 1'b0, "R8 reset outputs", int'({sda_oe, reg_wr, reg_rd}), 0);
        rst_n = 1'b1;
        tick(5);
        chk(sda_oe == 1'b0, "R8 idle after reset", int'(sda_oe), 0);

        // main function, several data and offset patterns
        do_write(8'h10, 8'hA5, "R2");
        do_read (8'h10, "R4");
        do_write(8'h00, 8'h5A, "R2");
        do_write(8'h7F, 8'hFF, "R3");
        do_write(8'hFE, 8'h00, "R3");
        do_read (8'h00, "R4");
        do_read (8'h7F, "R4");
        do_read (8'hFE, "R4");

        // bank switching
        do_write(8'hFF, 8'h02, "R5");
        do_read (8'hFF, "R5 bank readback");
        do_write(8'h10, 8'h3C, "R5");
        do_read (8'h10, "R5 bank 2 data");
        do_write(8'hFF, 8'h00, "R5");
        do_read (8'h10, "R5 bank 0 data kept");
        do_write(8'hFF, 8'h07, "R5 upper bits dropped");
        do_read (8'hFF, "R5 bank=3");
        do_write(8'h10, 8'h96, "R5");
        do_read (8'h10, "R5 bank 3 data");
        do_write(8'hFF, 8'h00, "R5");

        // foreign address
        begin
            bit a;
            m_start(); m_byte({7'h3B, 1'b0}, a);
            chk(!a, "R1 foreign write address NACK", int'(a), 0);
            m_bits(8'h10, 8); m_stop();
            m_start(); m_byte({7'h1A, 1'b1}, a); m_stop();
            chk(!a, "R1 foreign read address NACK", int'(a), 0);
            m_start(); m_byte({DEV, 1'b0}, a); m_byte(8'h10, a);
            m_rstart(); m_byte({7'h3B, 1'b1}, a); m_stop();
            chk(!a, "R1 foreign read address after command NACK", int'(a), 0);
        end

        // non-matching transactions
        begin
            bit a0, a1, a2, a3;
            m_start(); m_byte({DEV, 1'b1}, a0); m_stop();
            chk(!a0, "R6 read without command NACK", int'(a0), 0);
            model_write(8'h20, 8'h11);
            m_start(); m_byte({DEV, 1'b0}, a0); m_byte(8'h20, a1); m_byte(8'h11, a2);
            m_byte(8'hC3, a3); m_stop();
            chk(a2 && !a3, "R6 extra (PEC) byte NACK", int'({a2, a3}), 2);
            m_start(); m_byte({DEV, 1'b0}, a0); m_byte(8'h21, a1); m_stop();
            chk(a0 && a1, "R6 send-byte form acked then no write", int'({a0, a1}), 3);
            do_read(8'h20, "R6 single write landed");
            do_read(8'h21, "R6 command-only left data");
        end

        // abort by STOP and repeated START mid-byte
        begin
            bit a0, a1;
            m_start(); m_bits({DEV, 1'b0}, 4); m_stop();
            m_start(); m_byte({DEV, 1'b0}, a0); m_byte(8'h30, a1);
            m_bits(8'h77, 3); m_rstart(); m_stop();
            chk(sda_oe == 1'b0, "R7 SDA released after abort", int'(sda_oe), 0);
            m_start(); m_bits(8'hFF, 5); m_rstart(); m_byte({DEV, 1'b0}, a0);
            chk(a0, "R7 restart mid-byte then address acked", int'(a0), 1);
            m_stop();
            do_read (8'h30, "R7 aborted write left no data");
            do_write(8'h30, 8'h4B, "R7");
            do_read (8'h30, "R7 transfer after aborts");
        end

        tick(20);
        chk(exp_wq.size() == 0, "R3 all expected writes seen", exp_wq.size(), 0);
        chk(exp_rq.size() == 0, "R4 all expected reads seen", exp_rq.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule